// File: doc/BRIEF.md
# UART interrupt flag and enable controller

This block is the interrupt bookkeeping slice of a UART peripheral. It gathers status from the transmitter, the receiver and the modem-control logic into one status word. Some of those status bits are live levels, some are error or event pulses, and two are edges that the block detects itself. It also holds an interrupt enable mask whose bits sit at the same indices as the status bits they gate. A single interrupt request goes high whenever any enabled status bit is active.

Software reaches the block through a small word-addressed register port. Three word addresses are used:

- Word 0 reads the status. Writing ones to it clears the sticky flags.
- Word 1 sets enable bits.
- Word 2 clears enable bits.

Words 1 and 2 both read back the full enable mask. The serial engines that raise the events are outside this block. They drive level inputs and single-cycle pulse inputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable mask reads 0 at words 1 and 2, and the interrupt output is 0.
- R2: A write to word 1 sets every enable bit written as one. Enable bits written as zero keep their value.
- R3: A write to word 2 clears every enable bit written as one and leaves the others. Words 1 and 2 both return the current enable mask.
- R4: Only bits 0, 2, 3, 5, 6, 8, 11, 12, 13, 14, 15 and 16 are implemented (mask 0x0001F96D). All other bits are ignored on write and read as zero, and word 3 reads zero.
- R5: Status bit 0 (receive ready), bit 2 (transmit ready) and bit 3 (transmitter idle) follow their source inputs in the same cycle. Writing ones to word 0 does not change them.
- R6: Each of these flags is set by a one-cycle event pulse and stays set until a one is written to its bit at word 0: bit 6 (transmitter disabled), bit 8 (overrun), bit 12 (start detected), bit 13 (framing error), bit 14 (parity error), bit 15 (noise) and bit 16 (auto-baud error). Writing zero to the bit leaves the flag set.
- R7: Status bit 5 latches as a sticky flag when the CTS input rises or falls. It is cleared by writing one to it.
- R8: Status bit 11 latches as a sticky flag when the received-break input asserts and again when it deasserts. It is cleared by writing one to it.
- R9: If an event and a write-one-to-clear reach the same sticky flag in the same cycle, the flag ends set.
- R10: With the registered option (the default), the interrupt output equals the OR over all bits of status AND enable, delayed by one clock.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word address of the register access |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| src_rx_ready | input | 1 | Level: a received character is available |
| src_tx_ready | input | 1 | Level: the transmit holding register is free |
| src_tx_idle | input | 1 | Level: the transmitter is idle |
| cts_in | input | 1 | CTS line level, edges are detected |
| rx_break_in | input | 1 | Received-break detected level, edges are detected |
| ev_tx_off | input | 1 | Pulse: the transmitter became fully disabled |
| ev_overrun | input | 1 | Pulse: receive overrun |
| ev_start | input | 1 | Pulse: start bit detected |
| ev_frame_err | input | 1 | Pulse: framing error |
| ev_parity_err | input | 1 | Pulse: parity error |
| ev_noise | input | 1 | Pulse: noisy sample seen in a data bit |
| ev_abaud_err | input | 1 | Pulse: auto-baud timeout |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks a single one across all 32 bit positions, first through the set address and then through the clear address. A design that decoded the wrong bits, or that let zeros clear or set enables, would drift from the arithmetic mask the bench keeps. Each sticky source is pulsed on its own and then written zero and one. A flag that self-clears, ignores its clear, or lands at the wrong index shows up at once. Both edges of CTS and of break are driven, so a detector that sees only one direction leaves a flag unset.

The bench also tries to clear the level bits and checks that they stay up. It collides an overrun pulse with its own clear, which a clear-wins design would lose. It samples the interrupt output both the cycle a flag appears and the cycle after, which catches an output with no register or with an extra one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   // Number of low bits that carry implemented flags.
   localparam int unsigned FLAG_W = 17;

   // Bit indices shared by status and enable words.
   localparam int B_RX_READY = 0;
   localparam int B_TX_READY = 2;
   localparam int B_TX_IDLE  = 3;
   localparam int B_CTS_CHG  = 5;
   localparam int B_TX_OFF   = 6;
   localparam int B_OVERRUN  = 8;
   localparam int B_BRK_CHG  = 11;
   localparam int B_START    = 12;
   localparam int B_FRAME    = 13;
   localparam int B_PARITY   = 14;
   localparam int B_NOISE    = 15;
   localparam int B_ABAUD    = 16;

   localparam logic [31:0] LEVEL_MASK32 =
      (32'd1 << B_RX_READY) | (32'd1 << B_TX_READY) | (32'd1 << B_TX_IDLE);

   localparam logic [31:0] STICKY_MASK32 =
      (32'd1 << B_CTS_CHG) | (32'd1 << B_TX_OFF)  | (32'd1 << B_OVERRUN) |
      (32'd1 << B_BRK_CHG) | (32'd1 << B_START)   | (32'd1 << B_FRAME)   |
      (32'd1 << B_PARITY)  | (32'd1 << B_NOISE)   | (32'd1 << B_ABAUD);

   localparam logic [31:0] IMPL_MASK32 = LEVEL_MASK32 | STICKY_MASK32;

endpackage

// File: rtl/uart_irq_edge.sv
// Either-edge detector. The first cycle after reset only captures the level.
module uart_irq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   output logic chg_pulse
);

   logic prev_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         prev_q  <= lvl_in;
         armed_q <= 1'b1;
      end
   end

   assign chg_pulse = armed_q & (lvl_in ^ prev_q);

   // R7 / R8: a level that moves after arming must report a change on that cycle
   p_edge_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && (lvl_in != $past(lvl_in))) |-> chg_pulse);

endmodule

// File: rtl/uart_irq_sticky.sv
// Per-bit sticky flags: set by an event, cleared by writing one, set dominates.
module uart_irq_sticky #(
   parameter int unsigned      W    = 32,
   parameter logic [W-1:0]     KEEP = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] flags
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic flag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= ((flag_q & ~clr_vec[i]) | set_vec[i]) & KEEP[i];
      end

      assign flags[i] = flag_q;

      if (KEEP[i]) begin : g_chk
         // R9: an event in the same cycle as a clear leaves the flag set
         p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flag_q);
         // R6: without a clear the flag holds
         p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q && !clr_vec[i]) |=> flag_q);
      end
   end

endmodule

// File: rtl/uart_irq_enable.sv
// Enable mask written through separate set and clear strobes.
module uart_irq_enable #(
   parameter int unsigned  W    = 32,
   parameter logic [W-1:0] MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_set,
   input  logic         wr_clr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] en
);

   logic [W-1:0] set_bits;
   logic [W-1:0] clr_bits;

   assign set_bits = wr_set ? wdata : '0;
   assign clr_bits = wr_clr ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en <= '0;
      else        en <= (en | set_bits) & ~clr_bits & MASK;
   end

   // R2: every implemented bit written as one through the set strobe reads back set
   p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((en & $past(wdata & MASK)) == $past(wdata & MASK)));
   // R3: every bit written as one through the clear strobe reads back clear
   p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((en & $past(wdata)) == '0));
   // R3: untouched bits keep their value
   p_en_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_set && !wr_clr) |=> $stable(en));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned ADDR_W         = 2,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              src_rx_ready,
   input  logic              src_tx_ready,
   input  logic              src_tx_idle,
   input  logic              cts_in,
   input  logic              rx_break_in,
   input  logic              ev_tx_off,
   input  logic              ev_overrun,
   input  logic              ev_start,
   input  logic              ev_frame_err,
   input  logic              ev_parity_err,
   input  logic              ev_noise,
   input  logic              ev_abaud_err,
   output logic              irq
);

   localparam logic [DATA_W-1:0] M_LEVEL  = DATA_W'(LEVEL_MASK32);
   localparam logic [DATA_W-1:0] M_STICKY = DATA_W'(STICKY_MASK32);
   localparam logic [DATA_W-1:0] M_IMPL   = DATA_W'(IMPL_MASK32);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(2);

   if (DATA_W < FLAG_W || DATA_W > 32) begin : g_bad_width
      $error("uart_irq_ctrl: DATA_W must lie between FLAG_W and 32");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("uart_irq_ctrl: ADDR_W must be at least 2");
   end

   logic              wr_status, wr_set, wr_clr;
   logic              cts_chg, brk_chg;
   logic [DATA_W-1:0] level_vec, set_vec, clr_vec;
   logic [DATA_W-1:0] sticky_flags, status, en_mask;
   logic              any_hit;

   assign wr_status = reg_wr && (reg_addr == A_STATUS);
   assign wr_set    = reg_wr && (reg_addr == A_EN_SET);
   assign wr_clr    = reg_wr && (reg_addr == A_EN_CLR);

   uart_irq_edge u_cts_edge (
      .clk(clk), .rst_n(rst_n), .lvl_in(cts_in), .chg_pulse(cts_chg));

   uart_irq_edge u_brk_edge (
      .clk(clk), .rst_n(rst_n), .lvl_in(rx_break_in), .chg_pulse(brk_chg));

   always_comb begin
      level_vec             = '0;
      level_vec[B_RX_READY] = src_rx_ready;
      level_vec[B_TX_READY] = src_tx_ready;
      level_vec[B_TX_IDLE]  = src_tx_idle;

      set_vec             = '0;
      set_vec[B_CTS_CHG]  = cts_chg;
      set_vec[B_TX_OFF]   = ev_tx_off;
      set_vec[B_OVERRUN]  = ev_overrun;
      set_vec[B_BRK_CHG]  = brk_chg;
      set_vec[B_START]    = ev_start;
      set_vec[B_FRAME]    = ev_frame_err;
      set_vec[B_PARITY]   = ev_parity_err;
      set_vec[B_NOISE]    = ev_noise;
      set_vec[B_ABAUD]    = ev_abaud_err;
   end

   assign clr_vec = wr_status ? reg_wdata : '0;

   uart_irq_sticky #(.W(DATA_W), .KEEP(M_STICKY)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
      .flags(sticky_flags));

   uart_irq_enable #(.W(DATA_W), .MASK(M_IMPL)) u_enable (
      .clk(clk), .rst_n(rst_n), .wr_set(wr_set), .wr_clr(wr_clr),
      .wdata(reg_wdata), .en(en_mask));

   assign status  = (level_vec & M_LEVEL) | sticky_flags;
   assign any_hit = |(status & en_mask);

   always_comb begin
      case (reg_addr)
         A_STATUS: reg_rdata = status;
         A_EN_SET: reg_rdata = en_mask;
         A_EN_CLR: reg_rdata = en_mask;
         default:  reg_rdata = '0;
      endcase
   end

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_hit;
      end
      assign irq = irq_q;

      // R10: the request follows the masked status one clock later
      p_irq_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(any_hit)));
   end else begin : g_irq_comb
      assign irq = any_hit;
   end

   // R5: level bits in the status word track their sources
   p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status[B_RX_READY] == src_rx_ready) && (status[B_TX_IDLE] == src_tx_idle));

endmodule

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;

   localparam int DW = 32;
   localparam logic [31:0] IMPL = 32'h0001F96D;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic src_rx_ready = 0, src_tx_ready = 0, src_tx_idle = 0;
   logic cts_in = 0, rx_break_in = 0;
   logic ev_tx_off = 0, ev_overrun = 0, ev_start = 0, ev_frame_err = 0;
   logic ev_parity_err = 0, ev_noise = 0, ev_abaud_err = 0;
   logic irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uart_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .src_rx_ready(src_rx_ready), .src_tx_ready(src_tx_ready),
      .src_tx_idle(src_tx_idle), .cts_in(cts_in), .rx_break_in(rx_break_in),
      .ev_tx_off(ev_tx_off), .ev_overrun(ev_overrun), .ev_start(ev_start),
      .ev_frame_err(ev_frame_err), .ev_parity_err(ev_parity_err),
      .ev_noise(ev_noise), .ev_abaud_err(ev_abaud_err), .irq(irq));

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      tick();
      reg_wr    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic set_ev(int bitpos, logic v);
      case (bitpos)
         6:  ev_tx_off     = v;
         8:  ev_overrun    = v;
         12: ev_start      = v;
         13: ev_frame_err  = v;
         14: ev_parity_err = v;
         15: ev_noise      = v;
         16: ev_abaud_err  = v;
         default: ;
      endcase
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] exp_en;
      int evs[7] = '{6, 8, 12, 13, 14, 15, 16};

      tick(); tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      rd(2'd1, d); check("R1 enable word1", d, 32'h0);
      rd(2'd2, d); check("R1 enable word2", d, 32'h0);
      rd(2'd0, d); check("R1 status", d, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);

      // R2: walking ones through the set address
      exp_en = 0;
      for (int i = 0; i < 32; i++) begin
         wr(2'd1, 32'd1 << i);
         exp_en = (exp_en | (32'd1 << i)) & IMPL;
         rd(2'd1, d); check("R2 walk set", d, exp_en);
      end
      rd(2'd2, d); check("R3 readback word2", d, IMPL);

      // R3: walking ones through the clear address
      for (int i = 0; i < 32; i++) begin
         wr(2'd2, 32'd1 << i);
         exp_en = exp_en & ~(32'd1 << i);
         rd(2'd2, d); check("R3 walk clear", d, exp_en);
      end

      // R4: all ones hits only implemented bits; word 3 reads zero
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, d); check("R4 mask", d, IMPL);
      wr(2'd2, 32'h0000_0F0F);
      rd(2'd1, d); check("R3 partial clear", d, IMPL & ~32'h0000_0F0F);
      wr(2'd1, 32'h0000_0000);
      rd(2'd1, d); check("R2 zero write", d, IMPL & ~32'h0000_0F0F);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd3, d); check("R4 word3", d, 32'h0);
      wr(2'd2, 32'hFFFF_FFFF);
      rd(2'd1, d); check("R3 clear all", d, 32'h0);

      // R5: level bits follow, clear has no effect
      src_rx_ready = 1; src_tx_ready = 1; src_tx_idle = 1;
      rd(2'd0, d); check("R5 levels up", d, 32'h0000_000D);
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d); check("R5 levels after w1c", d, 32'h0000_000D);
      src_tx_ready = 0;
      rd(2'd0, d); check("R5 tx ready drop", d, 32'h0000_0009);
      src_rx_ready = 0; src_tx_idle = 0;
      rd(2'd0, d); check("R5 levels down", d, 32'h0);

      // R6: each pulse event is sticky
      foreach (evs[k]) begin
         set_ev(evs[k], 1'b1);
         tick();
         set_ev(evs[k], 1'b0);
         tick();
         rd(2'd0, d); check("R6 sticky set", d, 32'd1 << evs[k]);
         wr(2'd0, ~(32'd1 << evs[k]));
         rd(2'd0, d); check("R6 zero keeps", d, 32'd1 << evs[k]);
         wr(2'd0, 32'd1 << evs[k]);
         rd(2'd0, d); check("R6 w1c clears", d, 32'h0);
      end

      // R7: CTS both edges
      cts_in = 1; tick();
      rd(2'd0, d); check("R7 cts rise", d, 32'h0000_0020);
      wr(2'd0, 32'h20);
      rd(2'd0, d); check("R7 cts cleared", d, 32'h0);
      cts_in = 0; tick();
      rd(2'd0, d); check("R7 cts fall", d, 32'h0000_0020);
      wr(2'd0, 32'h20);

      // R8: break both edges
      rx_break_in = 1; tick();
      rd(2'd0, d); check("R8 break assert", d, 32'h0000_0800);
      wr(2'd0, 32'h800);
      tick();
      rd(2'd0, d); check("R8 steady break no flag", d, 32'h0);
      rx_break_in = 0; tick();
      rd(2'd0, d); check("R8 break release", d, 32'h0000_0800);
      wr(2'd0, 32'h800);
      rd(2'd0, d); check("R8 cleared", d, 32'h0);

      // R9: set and clear in the same cycle
      ev_overrun = 1;
      wr(2'd0, 32'h100);
      ev_overrun = 0;
      rd(2'd0, d); check("R9 set wins", d, 32'h0000_0100);
      wr(2'd0, 32'h100);
      rd(2'd0, d); check("R9 later clear", d, 32'h0);

      // R10: interrupt delay of one clock
      wr(2'd1, 32'h1000);
      check("R10 irq off no flag", {31'b0, irq}, 32'h0);
      ev_start = 1; tick(); ev_start = 0;
      check("R10 irq same cycle", {31'b0, irq}, 32'h0);
      tick();
      check("R10 irq next cycle", {31'b0, irq}, 32'h1);
      wr(2'd2, 32'h1000);
      check("R10 irq after disable write", {31'b0, irq}, 32'h1);
      tick();
      check("R10 irq dropped", {31'b0, irq}, 32'h0);
      src_tx_idle = 1;
      wr(2'd1, 32'h8);
      tick();
      check("R10 irq level source", {31'b0, irq}, 32'h1);
      src_tx_idle = 0;
      tick(); tick();
      check("R10 irq level gone", {31'b0, irq}, 32'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule